// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers interrupt requests for an 8-bit processor core and hands the core one vector address at a time. Requests come from eight external pins, twelve single-cycle event strobes, and a break-instruction strobe. Each pin has its own choice of active edge. The timers, serial channels and converter raise the event strobes. Every maskable source feeds a request latch in one of fifteen priority slots. Each slot has an enable bit. A global disable flag gates all the slots together. Five slots are shared between two sources, and a select bit picks which of the two can set the latch.

The controller ranks the candidates in a fixed order. A pending reset comes first. The fifteen maskable slots follow, with slot 0 ranked highest. The break instruction comes last, and it cannot be masked. The winner's vector is offered as the even address of a two-byte pair, and the high byte sits at that address plus one. The address stays fixed until the core acknowledges it. On acknowledge the controller clears only the winner's request and sets the global disable flag. The core clears the flag again through a dedicated input once it is ready for the next interrupt.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset, the global disable flag reads 1 and the first vector offered is FFFC (the reset vector). This vector stays pending until it is acknowledged.
- R2: The priority level L (1 = reset, 2..16 = slots 0..14, 17 = break) gives the low-byte address FFFC minus 2*(L-1). So slot s gives FFFA-2s and the break gives FFDC. Slot sources are as follows:
  - slot 0: pin 0
  - slot 1: pin 1 or strobe 0
  - slots 2..7: strobes 1..6
  - slots 8..11: pins 2..5, or strobes 7..10
  - slots 12..13: pins 6..7
  - slot 14: strobe 11
- R3: A maskable slot is offered only when three conditions hold together: its request is latched, its enable bit is 1, and the global disable flag is 0.
- R4: A pending reset wins over everything. Among the maskable slots, the lowest slot index wins. The break is offered only when no maskable slot is acceptable.
- R5: Pin p sets its request on a rising edge when pinRise[p]=1, and on a falling edge when pinRise[p]=0. The opposite edge has no effect.
- R6: A one-cycle pulse on evtStrobe[k] latches the request of the slot that strobe feeds.
- R7: For a shared slot, altSel=1 selects the strobe source and altSel=0 selects the pin source. Bit 0 of altSel controls slot 1, and bits 1..4 control slots 8..11. The deselected source is ignored. A request that is already latched survives a change of altSel.
- R8: A break pulse is offered even when the global disable flag is 1, and even when slot enables are 0.
- R9: While vecValid is 1 and cpuAck is 0, vecAddr holds its value. An acknowledge drops vecValid in the next cycle and clears only the winning request.
- R10: If a new request for a slot arrives in the same cycle as the acknowledge that clears it, the new request stays latched.
- R11: An acknowledge sets the global disable flag, and iFlagClr clears it. When both happen in the same cycle, the flag ends up set.
- R12: A latched request whose slot enable is 0 is kept. It is offered once the enable returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 8 | External interrupt pins |
| pinRise | input | 8 | Per-pin active edge: 1 = rising, 0 = falling |
| evtStrobe | input | 12 | One-cycle event strobes from internal peripherals |
| altSel | input | 5 | Source select for the five shared slots |
| slotEnable | input | 15 | Per-slot enable bits |
| brkReq | input | 1 | Break instruction strobe |
| cpuAck | input | 1 | Core acknowledges the offered vector |
| iFlagClr | input | 1 | Core clears the global disable flag |
| vecValid | output | 1 | A vector is being offered |
| vecAddr | output | 16 | Low-byte address of the offered vector pair |
| iFlag | output | 1 | Global disable flag |

## Verification
Two things can land on the same slot in the same clock: the acknowledge that clears a request, and a fresh event that sets it again. The bench raises a strobe for the slot that is being offered, and drives it in the same cycle as cpuAck. After the disable flag is released, the bench expects that same vector to come back. A second collision is between the acknowledge setting the disable flag and iFlagClr clearing it in the same cycle. For this case the bench expects the flag to read 1 afterwards.

// File: rtl/vec_irq_pkg.sv
package vec_irq_pkg;

  localparam int unsigned SLOT_COUNT   = 15;
  localparam int unsigned PIN_COUNT    = 8;
  localparam int unsigned STROBE_COUNT = 12;
  localparam int unsigned SHARED_COUNT = 5;
  localparam logic [15:0] TOP_VECTOR   = 16'hFFFC;

  // Control-to-datapath strobes, valid only in the acknowledge cycle.
  typedef struct packed {
    logic [SLOT_COUNT-1:0] clrSlot;
    logic                  clrBrk;
    logic                  clrRst;
    logic                  setIFlag;
  } ctrl_strobe_t;

  // Source index: pins occupy 0..PIN_COUNT-1, strobes follow.
  function automatic int primarySrc(input int s);
    case (s)
      0:  return 0;
      1:  return 1;
      2:  return 9;
      3:  return 10;
      4:  return 11;
      5:  return 12;
      6:  return 13;
      7:  return 14;
      8:  return 2;
      9:  return 3;
      10: return 4;
      11: return 5;
      12: return 6;
      13: return 7;
      default: return 19;
    endcase
  endfunction

  function automatic int altSrc(input int s);
    case (s)
      1:  return 8;
      8:  return 15;
      9:  return 16;
      10: return 17;
      11: return 18;
      default: return -1;
    endcase
  endfunction

  function automatic int sharedIdx(input int s);
    case (s)
      1:  return 0;
      8:  return 1;
      9:  return 2;
      10: return 3;
      11: return 4;
      default: return -1;
    endcase
  endfunction

endpackage

// File: rtl/vec_irq_datapath.sv
module vec_irq_datapath
  import vec_irq_pkg::*;
#(
  parameter int unsigned PINS    = PIN_COUNT,
  parameter int unsigned STROBES = STROBE_COUNT,
  parameter int unsigned SLOTS   = SLOT_COUNT,
  parameter int unsigned SHARED  = SHARED_COUNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PINS-1:0]    pinIn,
  input  logic [PINS-1:0]    pinRise,
  input  logic [STROBES-1:0] evtStrobe,
  input  logic [SHARED-1:0]  altSel,
  input  logic [SLOTS-1:0]   slotEnable,
  input  logic               brkReq,
  input  logic               iFlagClr,
  input  ctrl_strobe_t       st,
  output logic [SLOTS-1:0]   reqMasked,
  output logic               brkPend,
  output logic               rstPend,
  output logic               iFlag
);

  localparam int unsigned SOURCES = PINS + STROBES;

  logic [PINS-1:0]    pinPrev;
  logic               armed;
  logic [PINS-1:0]    pinEdge;
  logic [SOURCES-1:0] srcHit;
  logic [SLOTS-1:0]   slotHit;
  logic [SLOTS-1:0]   reqLatch;

  // Edges count only once a sample has been taken since reset.
  always_comb begin
    pinEdge = (pinRise & pinIn & ~pinPrev) | (~pinRise & ~pinIn & pinPrev);
    if (!armed) pinEdge = '0;
  end

  assign srcHit = {evtStrobe, pinEdge};

  for (genvar s = 0; s < SLOTS; s++) begin : g_route
    localparam int PRI = primarySrc(s);
    localparam int ALT = altSrc(s);
    localparam int SEL = sharedIdx(s);
    if (ALT >= 0) begin : g_shared
      assign slotHit[s] = altSel[SEL] ? srcHit[ALT] : srcHit[PRI];
    end else begin : g_single
      assign slotHit[s] = srcHit[PRI];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev  <= '0;
      armed    <= 1'b0;
      reqLatch <= '0;
      brkPend  <= 1'b0;
      rstPend  <= 1'b1;
      iFlag    <= 1'b1;
    end else begin
      pinPrev  <= pinIn;
      armed    <= 1'b1;
      // A set in the same cycle as its clear survives.
      reqLatch <= (reqLatch & ~st.clrSlot) | slotHit;
      brkPend  <= (brkPend & ~st.clrBrk) | brkReq;
      if (st.clrRst) rstPend <= 1'b0;
      if (st.setIFlag)   iFlag <= 1'b1;
      else if (iFlagClr) iFlag <= 1'b0;
    end
  end

  assign reqMasked = reqLatch & slotEnable;

endmodule

// File: rtl/vec_irq_control.sv
module vec_irq_control
  import vec_irq_pkg::*;
#(
  parameter int unsigned SLOTS = SLOT_COUNT
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SLOTS-1:0] reqMasked,
  input  logic             brkPend,
  input  logic             rstPend,
  input  logic             iFlag,
  input  logic             cpuAck,
  output ctrl_strobe_t     st,
  output logic             vecValid,
  output logic [15:0]      vecAddr
);

  localparam int unsigned BRK_LEVEL = SLOTS + 2;
  localparam int unsigned LVL_W     = $clog2(BRK_LEVEL + 1);
  localparam logic [LVL_W-1:0] RST_LVL = LVL_W'(1);
  localparam logic [LVL_W-1:0] BRK_LVL = LVL_W'(BRK_LEVEL);

  logic [SLOTS-1:0] eligible;
  logic             candValid;
  logic [LVL_W-1:0] candLevel;
  logic             holdValid;
  logic [LVL_W-1:0] holdLevel;
  logic             ackNow;

  assign eligible = reqMasked & {SLOTS{~iFlag}};

  always_comb begin
    candValid = 1'b0;
    candLevel = '0;
    if (rstPend) begin
      candValid = 1'b1;
      candLevel = RST_LVL;
    end else if (|eligible) begin
      candValid = 1'b1;
      for (int s = SLOTS - 1; s >= 0; s--)
        if (eligible[s]) candLevel = LVL_W'(s + 2);
    end else if (brkPend) begin
      candValid = 1'b1;
      candLevel = BRK_LVL;
    end
  end

  assign ackNow = holdValid & cpuAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdLevel <= '0;
    end else if (ackNow) begin
      holdValid <= 1'b0;
    end else if (!holdValid && candValid) begin
      holdValid <= 1'b1;
      holdLevel <= candLevel;
    end
  end

  always_comb begin
    st = '0;
    if (ackNow) begin
      st.setIFlag = 1'b1;
      st.clrRst   = (holdLevel == RST_LVL);
      st.clrBrk   = (holdLevel == BRK_LVL);
      for (int s = 0; s < SLOTS; s++)
        st.clrSlot[s] = (holdLevel == LVL_W'(s + 2));
    end
  end

  assign vecValid = holdValid;
  assign vecAddr  = TOP_VECTOR - {(16'(holdLevel) - 16'd1), 1'b0}[15:0];

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vec_irq_pkg::*;
#(
  parameter int unsigned PINS    = PIN_COUNT,
  parameter int unsigned STROBES = STROBE_COUNT,
  parameter int unsigned SLOTS   = SLOT_COUNT,
  parameter int unsigned SHARED  = SHARED_COUNT
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [PINS-1:0]    pinIn,
  input  logic [PINS-1:0]    pinRise,
  input  logic [STROBES-1:0] evtStrobe,
  input  logic [SHARED-1:0]  altSel,
  input  logic [SLOTS-1:0]   slotEnable,
  input  logic               brkReq,
  input  logic               cpuAck,
  input  logic               iFlagClr,
  output logic               vecValid,
  output logic [15:0]        vecAddr,
  output logic               iFlag
);

  ctrl_strobe_t     st;
  logic [SLOTS-1:0] reqMasked;
  logic             brkPend;
  logic             rstPend;

  vec_irq_datapath #(
    .PINS(PINS), .STROBES(STROBES), .SLOTS(SLOTS), .SHARED(SHARED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinRise(pinRise),
    .evtStrobe(evtStrobe), .altSel(altSel), .slotEnable(slotEnable),
    .brkReq(brkReq), .iFlagClr(iFlagClr), .st(st),
    .reqMasked(reqMasked), .brkPend(brkPend), .rstPend(rstPend), .iFlag(iFlag)
  );

  vec_irq_control #(.SLOTS(SLOTS)) u_ctl (
    .clk(clk), .rstN(rstN), .reqMasked(reqMasked), .brkPend(brkPend),
    .rstPend(rstPend), .iFlag(iFlag), .cpuAck(cpuAck), .st(st),
    .vecValid(vecValid), .vecAddr(vecAddr)
  );

endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cpuAck,
  input logic        vecValid,
  input logic [15:0] vecAddr,
  input logic        iFlag
);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && !cpuAck |=> vecValid && $stable(vecAddr));

  // R9
  ack_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && cpuAck |=> !vecValid);

  // R11
  ack_disable_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && cpuAck |=> iFlag);

  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr[0] == 1'b0 && vecAddr >= 16'hFFDC && vecAddr <= 16'hFFFC));

  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    vecValid && !$past(vecValid) && vecAddr != 16'hFFFC && vecAddr != 16'hFFDC
      |-> !$past(iFlag));

endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk u_chk (
  .clk(clk), .rstN(rstN), .cpuAck(cpuAck), .vecValid(vecValid),
  .vecAddr(vecAddr), .iFlag(iFlag)
);

// File: tb/vec_irq_ctrl_test.sv
module vec_irq_ctrl_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  pinIn = '0;
  logic [7:0]  pinRise = 8'b1011_1111;
  logic [11:0] evtStrobe = '0;
  logic [4:0]  altSel = '0;
  logic [14:0] slotEnable = '1;
  logic        brkReq = 1'b0;
  logic        cpuAck = 1'b0;
  logic        iFlagClr = 1'b0;
  logic        vecValid;
  logic [15:0] vecAddr;
  logic        iFlag;

  int          testsRun = 0;
  int          testsFailed = 0;
  bit          autoAck = 1'b0;
  bit          autoClr = 1'b1;
  bit          finished = 1'b0;
  string       curReq = "R1";
  logic [15:0] expQ[$];

  always #2.5 clk = ~clk;

  vec_irq_ctrl uut (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .pinRise(pinRise),
    .evtStrobe(evtStrobe), .altSel(altSel), .slotEnable(slotEnable),
    .brkReq(brkReq), .cpuAck(cpuAck), .iFlagClr(iFlagClr),
    .vecValid(vecValid), .vecAddr(vecAddr), .iFlag(iFlag)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic pushVec(input logic [15:0] a);
    expQ.push_back(a);
  endtask

  task automatic pulseStrobe(input int k);
    evtStrobe[k] = 1'b1;
    tick(1);
    evtStrobe[k] = 1'b0;
  endtask

  task automatic drain();
    int waited = 0;
    while (expQ.size() != 0 && waited < 300) begin
      tick(1);
      waited++;
    end
    testsRun++;
    if (expQ.size() != 0) begin
      testsFailed++;
      $display("FAIL %s drain: actual %0d left expected 0", curReq, expQ.size());
      expQ.delete();
    end
    tick(6);
  endtask

  // Scoreboard monitor: compares and acknowledges each offered vector.
  initial begin
    forever begin
      @(negedge clk);
      if (autoAck && vecValid) begin
        testsRun++;
        if (expQ.size() == 0) begin
          testsFailed++;
          $display("FAIL %s unexpected vector: actual %h expected none", curReq, vecAddr);
        end else begin
          logic [15:0] e;
          e = expQ.pop_front();
          if (vecAddr !== e) begin
            testsFailed++;
            $display("FAIL %s scoreboard: actual %h expected %h", curReq, vecAddr, e);
          end
        end
        cpuAck = 1'b1;
        @(negedge clk);
        cpuAck = 1'b0;
        if (autoClr) begin
          iFlagClr = 1'b1;
          @(negedge clk);
          iFlagClr = 1'b0;
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      testsRun++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    tick(3);
    rstN = 1'b1;
    tick(1);
    // R1: reset vector first, disable flag set
    check("R1", "reset vecValid", 16'(vecValid), 16'd1);
    check("R1", "reset vector", vecAddr, 16'hFFFC);
    check("R1", "reset iFlag", 16'(iFlag), 16'd1);
    tick(3);
    // R9: held while not acknowledged
    check("R9", "hold valid", 16'(vecValid), 16'd1);
    check("R9", "hold addr", vecAddr, 16'hFFFC);
    cpuAck = 1'b1;
    tick(1);
    cpuAck = 1'b0;
    check("R9", "drop after ack", 16'(vecValid), 16'd0);
    check("R11", "flag after ack", 16'(iFlag), 16'd1);

    // R3 / R6 / R8: masked by flag, break still offered
    autoAck = 1'b1;
    curReq = "R3";
    pulseStrobe(1);
    tick(5);
    check("R3", "masked by flag", 16'(vecValid), 16'd0);
    curReq = "R8";
    pushVec(16'hFFDC);
    pushVec(16'hFFF6);
    brkReq = 1'b1;
    tick(1);
    brkReq = 1'b0;
    drain();

    // R12: latched while disabled
    curReq = "R12";
    slotEnable[3] = 1'b0;
    pulseStrobe(2);
    tick(5);
    check("R12", "disabled slot silent", 16'(vecValid), 16'd0);
    pushVec(16'hFFF4);
    slotEnable[3] = 1'b1;
    drain();

    // R5: edge selection
    curReq = "R5";
    pushVec(16'hFFFA);
    pinIn[0] = 1'b1;
    drain();
    pinIn[0] = 1'b0;
    tick(5);
    check("R5", "falling ignored on rising pin", 16'(expQ.size()), 16'd0);
    pinIn[6] = 1'b1;
    tick(5);
    check("R5", "rising ignored on falling pin", 16'(vecValid), 16'd0);
    pushVec(16'hFFE2);
    pinIn[6] = 1'b0;
    drain();

    // R7: shared slot select
    curReq = "R7";
    pulseStrobe(0);
    tick(5);
    check("R7", "deselected strobe", 16'(vecValid), 16'd0);
    altSel[0] = 1'b1;
    pushVec(16'hFFF8);
    pulseStrobe(0);
    drain();
    pinIn[1] = 1'b1;
    tick(5);
    check("R7", "deselected pin", 16'(vecValid), 16'd0);
    pinIn[1] = 1'b0;
    slotEnable[1] = 1'b0;
    pulseStrobe(0);
    altSel[0] = 1'b0;
    tick(3);
    pushVec(16'hFFF8);
    slotEnable[1] = 1'b1;
    drain();

    // R4 / R9: several pending, served in order, others kept
    curReq = "R4";
    slotEnable = '0;
    pinIn[0] = 1'b1;
    evtStrobe[4] = 1'b1;
    evtStrobe[11] = 1'b1;
    tick(1);
    evtStrobe = '0;
    tick(4);
    check("R4", "all disabled", 16'(vecValid), 16'd0);
    pushVec(16'hFFFA);
    pushVec(16'hFFF0);
    pushVec(16'hFFDE);
    slotEnable = '1;
    drain();
    pinIn[0] = 1'b0;
    tick(2);

    // R4 / R8: break below maskable, then offered despite flag
    autoAck = 1'b0;
    tick(2);
    brkReq = 1'b1;
    evtStrobe[4] = 1'b1;
    tick(1);
    brkReq = 1'b0;
    evtStrobe[4] = 1'b0;
    tick(1);
    check("R4", "maskable beats break", vecAddr, 16'hFFF0);
    cpuAck = 1'b1;
    tick(1);
    cpuAck = 1'b0;
    tick(1);
    check("R8", "break with flag set", vecAddr, 16'hFFDC);
    check("R8", "break valid", 16'(vecValid), 16'd1);
    cpuAck = 1'b1;
    tick(1);
    cpuAck = 1'b0;
    iFlagClr = 1'b1;
    tick(1);
    iFlagClr = 1'b0;
    tick(3);

    // R10: set and clear in the same cycle
    curReq = "R10";
    pulseStrobe(3);
    tick(1);
    check("R10", "first offer", vecAddr, 16'hFFF2);
    cpuAck = 1'b1;
    evtStrobe[3] = 1'b1;
    tick(1);
    cpuAck = 1'b0;
    evtStrobe[3] = 1'b0;
    check("R10", "drop after ack", 16'(vecValid), 16'd0);
    iFlagClr = 1'b1;
    tick(1);
    iFlagClr = 1'b0;
    tick(1);
    check("R10", "request survived", vecAddr, 16'hFFF2);
    check("R10", "request valid", 16'(vecValid), 16'd1);

    // R11: ack and clear together leave flag set
    cpuAck = 1'b1;
    iFlagClr = 1'b1;
    tick(1);
    cpuAck = 1'b0;
    iFlagClr = 1'b0;
    check("R11", "ack wins over clear", 16'(iFlag), 16'd1);
    tick(4);
    check("R9", "only winner cleared, none left", 16'(vecValid), 16'd0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule